// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is one memory-to-memory transfer channel. Software loads a source address, a destination address, a unit count and a 16-bit control word through a small write port. When the enable bit in the control word goes from 0 to 1, the channel takes working copies of the three programmed values. It then waits for the start condition selected in the control word. On that condition it copies the requested number of 16-bit or 32-bit units over a single valid/ready master bus. Each unit is one read followed by one write of the data that was read.

After each unit, both addresses step up, step down or stay where they are. The step is 2 for halfwords and 4 for words. When a run completes, the channel issues a one-cycle done pulse and, if requested, a one-cycle interrupt pulse. It then drops its enable bit, unless the repeat bit is set. In repeat mode the channel stays enabled and rearms for the next trigger. On rearm it refreshes the count from the programmed register. It refreshes the destination only in increment-and-restore mode. It never refreshes the source. Software stops a repeating channel by clearing enable.

The controller has five states:
- IDLE: no transfer pending.
- ARMED: waiting for the start condition.
- READ: read request on the bus.
- WRITE: write request on the bus.
- FINISH: one completion cycle.

The transitions are:
- IDLE to ARMED on an enable rising edge.
- ARMED to IDLE when enable is cleared.
- ARMED to READ when the start condition fires.
- READ to WRITE on read acceptance.
- WRITE to READ when more units remain.
- WRITE to IDLE when enable was cleared mid-run.
- WRITE to FINISH after the last unit.
- FINISH to ARMED when repeating.
- FINISH to IDLE otherwise.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset the control readback is 0, no bus request is raised, and neither done_pulse nor irq_pulse is high.
- R2: The control word layout is as follows. Bit 15 is enable. Bit 14 requests an interrupt. Bits 13:12 select the start condition. Bit 10 selects 32-bit units. Bit 9 is repeat. Bits 8:7 hold the source mode. Bits 6:5 hold the destination mode. Bits 11 and 4:0 read back as 0; every other bit reads back as written.
- R3: A control write that takes enable from 0 to 1 copies source, destination and count into the working registers, with the two low address bits cleared. Each unit is then a read at the working source, followed by a write of the returned data to the working destination.
- R4: The address modes are: 0 adds the step, 1 subtracts it, and 2 keeps the address. Destination mode 3 adds the step. Source mode 3 keeps the address. The step is 2 for halfword units and 4 for word units.
- R5: Only the low CNT_W bits of the count register are used, and a value of 0 there means 2^CNT_W units.
- R6: The start selections are: 0 starts at once; 1, 2 and 3 wait for a pulse on trig_frame, trig_line or trig_aux respectively. Pulses on the other two trigger inputs start nothing.
- R7: done_pulse is high for one cycle, directly after the last write is accepted. irq_pulse is high in the same cycle when bit 14 is set. Enable then reads back 0 unless repeat is set.
- R8: With repeat set, enable stays 1 and the channel waits for its next trigger. The count is reloaded from the programmed register. The destination is reloaded only in mode 3. The source continues from where it stopped. Clearing enable while waiting stops the channel.
- R9: If enable is cleared during a run, the unit in progress completes, no further unit starts, and no done pulse is given.
- R10: A software control write in the FINISH cycle wins over the automatic enable clear. Enable then reads back 1, but no transfer starts until enable is cleared and set again.
- R11: While a request is waiting for bus_ready, its address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 16 | Control word readback |
| trig_frame | input | 1 | Start pulse for start selection 1 |
| trig_line | input | 1 | Start pulse for start selection 2 |
| trig_aux | input | 1 | Start pulse for start selection 3 |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_word | output | 1 | 1 for 32-bit unit, 0 for 16-bit unit |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Request accepted this cycle; read data valid |
| bus_rdata | input | 32 | Read data |
| done_pulse | output | 1 | One-cycle completion pulse |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can fall in the same cycle: the completion cycle, where the engine clears enable, and a software control write. The bench provokes this by watching for done_pulse on a falling edge and placing a control write in that same cycle. It judges the outcome on three counts. Enable must read back as written. A trigger afterwards must produce no bus request. Only a clear-then-set sequence may start the next run. A second overlap is tested by clearing enable while a read is held off by bus_ready. The bench checks that exactly one unit, and no done pulse, follow.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        AM_INC     = 2'd0,
        AM_DEC     = 2'd1,
        AM_FIX     = 2'd2,
        AM_INC_RLD = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        GO_NOW   = 2'd0,
        GO_FRAME = 2'd1,
        GO_LINE  = 2'd2,
        GO_AUX   = 2'd3
    } start_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_READ,
        S_WRITE,
        S_FINISH
    } xfer_state_e;

    typedef struct packed {
        logic       enable;
        logic       irq_en;
        start_sel_e start;
        logic       rsvd_hi;
        logic       word;
        logic       rpt;
        addr_mode_e src_mode;
        addr_mode_e dst_mode;
        logic [4:0] rsvd_lo;
    } ctrl_t;

    localparam logic [1:0]  SEL_SRC   = 2'd0;
    localparam logic [1:0]  SEL_DST   = 2'd1;
    localparam logic [1:0]  SEL_CNT   = 2'd2;
    localparam logic [1:0]  SEL_CTRL  = 2'd3;
    localparam logic [15:0] CTRL_MASK = 16'hF7E0;

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              clr_en,
    output logic [ADDR_W-1:0] prog_src,
    output logic [ADDR_W-1:0] prog_dst,
    output logic [CNT_W-1:0]  prog_cnt,
    output ctrl_t             ctrl,
    output logic              en_rise
);

    logic ctrl_wr;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign en_rise = ctrl_wr && wr_data[15] && !ctrl.enable;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_src <= '0;
            prog_dst <= '0;
            prog_cnt <= '0;
            ctrl     <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_SRC) prog_src <= wr_data[ADDR_W-1:0];
            if (wr_en && wr_sel == SEL_DST) prog_dst <= wr_data[ADDR_W-1:0];
            if (wr_en && wr_sel == SEL_CNT) prog_cnt <= wr_data[CNT_W-1:0];
            if (ctrl_wr)     ctrl        <= ctrl_t'(wr_data[15:0] & CTRL_MASK);
            else if (clr_en) ctrl.enable <= 1'b0;
        end
    end

    // R10
    enable_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.enable) |-> $past(wr_en && wr_sel == SEL_CTRL));

    // R7
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !ctrl_wr) |=> !ctrl.enable);

endmodule

// File: rtl/dma_xfer_addr_step.sv
module dma_xfer_addr_step
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter bit ALLOW_RELOAD = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  addr_mode_e        mode,
    input  logic              word,
    output logic [ADDR_W-1:0] next
);

    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] up;
    logic [ADDR_W-1:0] down;

    assign stride = word ? ADDR_W'(4) : ADDR_W'(2);
    assign up     = addr + stride;
    assign down   = addr - stride;

    generate
        if (ALLOW_RELOAD) begin : g_dst
            always_comb begin
                unique case (mode)
                    AM_INC, AM_INC_RLD: next = up;
                    AM_DEC:             next = down;
                    default:            next = addr;
                endcase
            end
        end else begin : g_src
            always_comb begin
                unique case (mode)
                    AM_INC:  next = up;
                    AM_DEC:  next = down;
                    default: next = addr;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_rise,
    input  logic              enable,
    input  logic              rpt,
    input  logic              word,
    input  logic              irq_en,
    input  start_sel_e        start,
    input  addr_mode_e        dst_mode,
    input  logic [ADDR_W-1:0] prog_src,
    input  logic [ADDR_W-1:0] prog_dst,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic              trig_frame,
    input  logic              trig_line,
    input  logic              trig_aux,
    input  logic [ADDR_W-1:0] src_next,
    input  logic [ADDR_W-1:0] dst_next,
    output logic [ADDR_W-1:0] wk_src,
    output logic [ADDR_W-1:0] wk_dst,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    output logic              done_pulse,
    output logic              irq_pulse,
    output logic              clr_en
);

    localparam int           WK_W   = CNT_W + 1;
    localparam logic [WK_W-1:0] WK_ONE = WK_W'(1);

    xfer_state_e       st, nxt;
    logic [WK_W-1:0]   wk_cnt;
    logic [31:0]       data_q;
    logic              fire;
    logic [WK_W-1:0]   cnt_load;
    logic [ADDR_W-1:0] src_al, dst_al;

    assign cnt_load = (prog_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, prog_cnt};
    assign src_al   = {prog_src[ADDR_W-1:2], 2'b00};
    assign dst_al   = {prog_dst[ADDR_W-1:2], 2'b00};

    always_comb begin
        unique case (start)
            GO_NOW:   fire = 1'b1;
            GO_FRAME: fire = trig_frame;
            GO_LINE:  fire = trig_line;
            GO_AUX:   fire = trig_aux;
        endcase
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (en_rise) nxt = S_ARMED;
            S_ARMED:  if (!enable) nxt = S_IDLE;
                      else if (fire) nxt = S_READ;
            S_READ:   if (bus_ready) nxt = S_WRITE;
            S_WRITE:  if (bus_ready) begin
                          if (wk_cnt == WK_ONE) nxt = S_FINISH;
                          else if (!enable)     nxt = S_IDLE;
                          else                  nxt = S_READ;
                      end
            S_FINISH: nxt = (rpt && enable) ? S_ARMED : S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_src <= '0;
            wk_dst <= '0;
            wk_cnt <= '0;
            data_q <= '0;
        end else if (en_rise) begin
            wk_src <= src_al;
            wk_dst <= dst_al;
            wk_cnt <= cnt_load;
        end else begin
            if (st == S_READ && bus_ready) begin
                data_q <= bus_rdata;
                wk_src <= src_next;
            end
            if (st == S_WRITE && bus_ready) begin
                wk_dst <= dst_next;
                wk_cnt <= wk_cnt - WK_ONE;
            end
            if (st == S_FINISH && rpt && enable) begin
                wk_cnt <= cnt_load;
                if (dst_mode == AM_INC_RLD) wk_dst <= dst_al;
            end
        end
    end

    always_comb begin
        bus_valid  = (st == S_READ) || (st == S_WRITE);
        bus_write  = (st == S_WRITE);
        bus_word   = word;
        bus_addr   = (st == S_WRITE) ? wk_dst : wk_src;
        bus_wdata  = data_q;
        done_pulse = (st == S_FINISH);
        irq_pulse  = (st == S_FINISH) && irq_en;
        clr_en     = (st == S_FINISH) && !rpt;
    end

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_write) && $stable(bus_wdata)));

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(bus_valid && bus_ready && bus_write));

    // R3
    unit_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write));

    // R9
    stop_mid_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_ready && !enable && wk_cnt != WK_ONE)
            |=> (!bus_valid && !done_pulse));

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [15:0]       ctrl_rdata,
    input  logic              trig_frame,
    input  logic              trig_line,
    input  logic              trig_aux,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    output logic              done_pulse,
    output logic              irq_pulse
);

    ctrl_t             ctrl;
    logic              en_rise, clr_en;
    logic [ADDR_W-1:0] prog_src, prog_dst;
    logic [CNT_W-1:0]  prog_cnt;
    logic [ADDR_W-1:0] wk_src, wk_dst, src_next, dst_next;

    assign ctrl_rdata = ctrl;

    dma_xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .clr_en(clr_en),
        .prog_src(prog_src), .prog_dst(prog_dst), .prog_cnt(prog_cnt),
        .ctrl(ctrl), .en_rise(en_rise)
    );

    dma_xfer_addr_step #(.ADDR_W(ADDR_W), .ALLOW_RELOAD(1'b0)) u_src_step (
        .addr(wk_src), .mode(ctrl.src_mode), .word(ctrl.word), .next(src_next)
    );

    dma_xfer_addr_step #(.ADDR_W(ADDR_W), .ALLOW_RELOAD(1'b1)) u_dst_step (
        .addr(wk_dst), .mode(ctrl.dst_mode), .word(ctrl.word), .next(dst_next)
    );

    dma_xfer_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en_rise(en_rise), .enable(ctrl.enable), .rpt(ctrl.rpt),
        .word(ctrl.word), .irq_en(ctrl.irq_en), .start(ctrl.start),
        .dst_mode(ctrl.dst_mode),
        .prog_src(prog_src), .prog_dst(prog_dst), .prog_cnt(prog_cnt),
        .trig_frame(trig_frame), .trig_line(trig_line), .trig_aux(trig_aux),
        .src_next(src_next), .dst_next(dst_next),
        .wk_src(wk_src), .wk_dst(wk_dst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .done_pulse(done_pulse), .irq_pulse(irq_pulse), .clr_en(clr_en)
    );

endmodule

// File: tb/dma_xfer_channel_tb.sv
`timescale 1ns/1ps
module dma_xfer_channel_tb;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic        wr;
        logic        word;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] ctrl_rdata;
    logic        trig_frame = 1'b0, trig_line = 1'b0, trig_aux = 1'b0;
    logic        bus_valid, bus_write, bus_word;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready = 1'b1;
    logic        done_pulse, irq_pulse;

    item_t exp_q[$];
    string tag_q[$];
    int checks = 0, fails = 0;
    int done_cnt = 0, irq_cnt = 0, act_cnt = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
    endfunction

    assign bus_rdata = rdm(bus_addr);

    dma_xfer_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata),
        .trig_frame(trig_frame), .trig_line(trig_line), .trig_aux(trig_aux),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .done_pulse(done_pulse), .irq_pulse(irq_pulse)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_unit(input logic [31:0] s, input logic [31:0] d,
                             input logic w, input string tag);
        exp_q.push_back('{wr: 1'b0, word: w, addr: s, data: 32'h0});
        tag_q.push_back(tag);
        exp_q.push_back('{wr: 1'b1, word: w, addr: d, data: rdm(s)});
        tag_q.push_back(tag);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) trig_frame = 1'b1;
        if (which == 2) trig_line  = 1'b1;
        if (which == 3) trig_aux   = 1'b1;
        @(negedge clk);
        trig_frame = 1'b0; trig_line = 1'b0; trig_aux = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // monitor: pops expected bus items as handshakes happen
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (bus_valid) act_cnt++;
            if (done_pulse) done_cnt++;
            if (irq_pulse) irq_cnt++;
            if (bus_valid && bus_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected bus item", bus_addr, 32'h0);
                end else begin
                    item_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_write == e.wr && bus_word == e.word && bus_addr == e.addr,
                          {t, " addr/dir"}, bus_addr, e.addr);
                    if (e.wr) check(bus_wdata == e.data, {t, " data"}, bus_wdata, e.data);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int dexp;
        int act0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctrl_rdata == 16'h0, "R1 ctrl", ctrl_rdata, 0);
        check(!bus_valid && !done_pulse && !irq_pulse, "R1 outputs", bus_valid, 0);

        // R2 readback masks reserved bits
        cfg(2'd3, 32'h0000_7FFF);
        check(ctrl_rdata == 16'h77E0, "R2 readback", ctrl_rdata, 16'h77E0);
        cfg(2'd3, 32'h0);

        // R3 R4 words inc/inc, aligned, immediate start
        dexp = 0;
        cfg(2'd0, 32'h1003); cfg(2'd1, 32'h2001); cfg(2'd2, 3);
        for (int i = 0; i < 3; i++) push_unit(32'h1000 + 4*i, 32'h2000 + 4*i, 1'b1, "R3");
        cfg(2'd3, 32'h8400);
        drain("R3 drain");
        dexp++;
        check(done_cnt == dexp, "R7 done count", done_cnt, dexp);
        check(irq_cnt == 0, "R7 no irq", irq_cnt, 0);
        check(ctrl_rdata == 16'h0400, "R7 enable cleared", ctrl_rdata, 16'h0400);

        // R4 halfword, source dec, dest fixed, irq
        cfg(2'd0, 32'h3000); cfg(2'd1, 32'h4000); cfg(2'd2, 4);
        for (int i = 0; i < 4; i++) push_unit(32'h3000 - 2*i, 32'h4000, 1'b0, "R4");
        cfg(2'd3, 32'hC0C0);
        drain("R4 drain");
        dexp++;
        check(done_cnt == dexp, "R7 done count hw", done_cnt, dexp);
        check(irq_cnt == 1, "R7 irq", irq_cnt, 1);

        // R5 zero count means 2^CNT_W; R4 source mode 3 fixed
        cfg(2'd0, 32'hC000); cfg(2'd1, 32'hD000); cfg(2'd2, 0);
        for (int i = 0; i < 16; i++) push_unit(32'hC000, 32'hD000 + 4*i, 1'b1, "R5 zero");
        cfg(2'd3, 32'h8580);
        drain("R5 zero drain");
        dexp++;
        check(done_cnt == dexp, "R5 done", done_cnt, dexp);
        cfg(2'd2, 32'h13);
        for (int i = 0; i < 3; i++) push_unit(32'hC000, 32'hD000 + 4*i, 1'b1, "R5 trunc");
        cfg(2'd3, 32'h8580);
        drain("R5 trunc drain");
        dexp++;

        // R6 R8 frame trigger, repeat, dest restore
        cfg(2'd0, 32'h5000); cfg(2'd1, 32'h6000); cfg(2'd2, 2);
        cfg(2'd3, 32'h9660);
        cfg(2'd2, 3); cfg(2'd0, 32'h7000);
        act0 = act_cnt;
        repeat (5) @(negedge clk);
        pulse(2); pulse(3);
        repeat (5) @(negedge clk);
        check(act_cnt == act0, "R6 wrong trigger ignored", act_cnt, act0);
        for (int i = 0; i < 2; i++) push_unit(32'h5000 + 4*i, 32'h6000 + 4*i, 1'b1, "R6");
        pulse(1);
        drain("R6 drain");
        dexp++;
        check(done_cnt == dexp, "R8 first run done", done_cnt, dexp);
        check(ctrl_rdata == 16'h9660, "R8 enable kept", ctrl_rdata, 16'h9660);
        for (int i = 0; i < 3; i++) push_unit(32'h5008 + 4*i, 32'h6000 + 4*i, 1'b1, "R8");
        pulse(1);
        drain("R8 drain");
        dexp++;
        check(done_cnt == dexp, "R8 second run done", done_cnt, dexp);
        cfg(2'd3, 32'h1660);
        act0 = act_cnt;
        pulse(1);
        repeat (10) @(negedge clk);
        check(act_cnt == act0, "R8 stopped", act_cnt, act0);

        // R9 R11 clear enable while read is stalled
        bus_ready = 1'b0;
        cfg(2'd0, 32'h8000); cfg(2'd1, 32'h9000); cfg(2'd2, 5);
        cfg(2'd3, 32'h8400);
        repeat (3) @(negedge clk);
        check(bus_valid && !bus_write && bus_addr == 32'h8000, "R11 held", bus_addr, 32'h8000);
        cfg(2'd3, 32'h0400);
        check(bus_valid && bus_addr == 32'h8000, "R11 held after clear", bus_addr, 32'h8000);
        push_unit(32'h8000, 32'h9000, 1'b1, "R9");
        @(negedge clk);
        bus_ready = 1'b1;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && !bus_valid, "R9 one unit only", exp_q.size(), 0);
        check(done_cnt == dexp, "R9 no done", done_cnt, dexp);

        // R10 control write in the completion cycle
        cfg(2'd0, 32'hA000); cfg(2'd1, 32'hB000); cfg(2'd2, 2);
        for (int i = 0; i < 2; i++) push_unit(32'hA000 + 4*i, 32'hB000 + 4*i, 1'b1, "R10 run");
        cfg(2'd3, 32'h8400);
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!done_pulse && n < 200);
        end
        cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h9400;
        @(negedge clk);
        cfg_wr = 1'b0;
        dexp++;
        check(ctrl_rdata == 16'h9400, "R10 write wins", ctrl_rdata, 16'h9400);
        act0 = act_cnt;
        pulse(1);
        repeat (10) @(negedge clk);
        check(act_cnt == act0, "R10 no start without rise", act_cnt, act0);
        cfg(2'd3, 32'h1400);
        for (int i = 0; i < 2; i++) push_unit(32'hA000 + 4*i, 32'hB000 + 4*i, 1'b1, "R10 rerun");
        cfg(2'd3, 32'h9400);
        pulse(1);
        drain("R10 drain");
        dexp++;
        check(done_cnt == dexp, "R10 done", done_cnt, dexp);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule